// File: doc/BRIEF.md
# Dual-Mode Instruction Fetch Front End

This block sits at the front of a small 32-bit processor core. The core runs two instruction encodings: a wide encoding with 32-bit instructions and a narrow encoding with 16-bit instructions. The block keeps a one-bit mode flag and fetches over a 16-bit memory bus. In wide mode it joins two halfwords into one instruction word. In narrow mode it hands each halfword on as an instruction. Each instruction it delivers carries its address, a width flag, and the program-counter value that instructions observe.

Three redirect sources move the fetch stream and can change the mode:
- A branch-with-mode-change takes the new mode from the low bit of its target.
- An exception forces wide mode and jumps to a fixed vector.
- An exception return restores the mode from a saved status bit.

Every redirect discards any half-built word and any instruction not yet delivered. Fetching restarts at the aligned new address one cycle later.

Memory reads use a simple request handshake. A halfword moves on any cycle where `mem_req_valid` and `mem_req_ready` are both high. On that cycle `mem_rsp_data` carries the halfword at `mem_req_addr`.

The instruction output is a valid/ready stream. An instruction moves when `instr_valid` and `instr_ready` are both high. While `instr_ready` is low, the block holds the instruction unchanged. Back-pressure on the output stops the bus as soon as no room is left. The first halfword of a wide instruction may still be fetched into the join buffer while the output is stalled.

Top module: `dual_isa_fetch`

## Requirements
- R1: After reset the mode flag `cur_mode` is 0 (wide), `instr_valid` is 0 and `mem_req_addr` equals the RESET_ADDR parameter (0 by default).
- R2: A branch request (`br_valid`) sets the mode from bit 0 of `br_target` (1 = narrow, 0 = wide). Fetching restarts at the target with bit 0 cleared in narrow mode, or with bits 1:0 cleared in wide mode.
- R3: In wide mode each instruction takes two bus transfers. The halfword at the lower address becomes `instr_data[15:0]`, the next halfword becomes `instr_data[31:16]`, and `instr_wide` is 1.
- R4: In narrow mode each instruction takes one bus transfer. The halfword appears in `instr_data[15:0]`, `instr_data[31:16]` is zero, and `instr_wide` is 0.
- R5: Each bus transfer advances the fetch address by 2. Consecutive delivered instructions therefore have `instr_pc` 4 apart in wide mode and 2 apart in narrow mode.
- R6: `exc_req` forces wide mode and restarts fetching at EXC_VECTOR. It takes priority over a return or a branch in the same cycle.
- R7: An exception return (`eret_valid`) takes its mode from `eret_mode`, never from bit 0 of `eret_addr`. It restarts at `eret_addr` aligned for that mode, and it takes priority over a branch in the same cycle.
- R8: `pc_view` equals `instr_pc` + 8 for a wide instruction and `instr_pc` + 4 for a narrow one.
- R9: A redirect drops any half-joined word and any undelivered instruction. The first instruction delivered afterwards is the one at the new address, in the new mode.
- R10: While `instr_valid` is high and `instr_ready` is low, `instr_valid`, `instr_data`, `instr_pc` and `instr_wide` hold their values, unless a redirect flushes them.
- R11: While `mem_req_ready` is low, `mem_req_addr` holds its value. `mem_req_addr[0]` is 0 whenever `mem_req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch-with-mode-change request, one-cycle pulse |
| br_target | input | AW | Branch target; bit 0 selects the new mode |
| exc_req | input | 1 | Exception entry request, one-cycle pulse |
| eret_valid | input | 1 | Exception return request, one-cycle pulse |
| eret_addr | input | AW | Return address |
| eret_mode | input | 1 | Saved mode bit restored on return |
| mem_req_valid | output | 1 | Halfword read request |
| mem_req_ready | input | 1 | Memory accepts the request; data valid this cycle |
| mem_req_addr | output | AW | Halfword read address |
| mem_rsp_data | input | 16 | Halfword returned for the accepted request |
| instr_valid | output | 1 | Instruction available |
| instr_ready | input | 1 | Consumer takes the instruction |
| instr_data | output | 32 | Instruction bits |
| instr_wide | output | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| instr_pc | output | AW | Address of the delivered instruction |
| pc_view | output | AW | Program counter as seen by the instruction |
| cur_mode | output | 1 | Current fetch mode, 0 = wide, 1 = narrow |

## Verification
The properties assume that each redirect input is a single-cycle pulse. They also assume that `mem_rsp_data` is valid on every cycle the memory raises `mem_req_ready`. The stimulus meets both assumptions:
- Each redirect is driven for exactly one clock and then removed.
- The memory model derives the returned halfword combinationally from the requested address.

Ready patterns on both the memory and the output side introduce stalls. Redirects are applied only while the output is stalled. This way they land with a pending instruction, and in wide mode also a half-joined word, sitting in the block.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic {
    ISA_WIDE   = 1'b0,
    ISA_NARROW = 1'b1
  } isa_e;

  localparam int HW_BITS   = 16;
  localparam int WORD_BITS = 2 * HW_BITS;
  localparam int WIDE_PC_AHEAD   = 8;
  localparam int NARROW_PC_AHEAD = 4;
  localparam int HW_STEP = HW_BITS / 8;
endpackage

// File: rtl/fetch_redirect.sv
module fetch_redirect
  import fetch_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] EXC_VECTOR = 32'h0000_0040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic          ret_req,
  input  logic [AW-1:0] ret_addr,
  input  logic          ret_mode,
  input  logic          br_req,
  input  logic [AW-1:0] br_target,
  output logic          take,
  output isa_e          new_mode,
  output logic [AW-1:0] new_addr
);
  logic [AW-1:0] raw_addr;

  always_comb begin
    take     = exc_req | ret_req | br_req;
    new_mode = ISA_WIDE;
    raw_addr = '0;
    if (exc_req) begin
      new_mode = ISA_WIDE;
      raw_addr = EXC_VECTOR;
    end else if (ret_req) begin
      new_mode = isa_e'(ret_mode);
      raw_addr = ret_addr;
    end else if (br_req) begin
      new_mode = isa_e'(br_target[0]);
      raw_addr = br_target;
    end
  end

  always_comb begin
    if (new_mode == ISA_NARROW) new_addr = {raw_addr[AW-1:1], 1'b0};
    else                        new_addr = {raw_addr[AW-1:2], 2'b00};
  end

  // R6
  exc_forces_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (new_mode == ISA_WIDE && new_addr == EXC_VECTOR));

  // R7
  ret_mode_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !exc_req) |-> (new_mode == isa_e'(ret_mode) && new_addr[AW-1:2] == ret_addr[AW-1:2]));
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  isa_e          new_mode,
  input  logic [AW-1:0] new_addr,
  input  logic          xfer,
  output isa_e          mode,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP = AW'(HW_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= ISA_WIDE;
      addr <= RESET_ADDR;
    end else if (take) begin
      mode <= new_mode;
      addr <= new_addr;
    end else if (xfer) begin
      addr <= addr + STEP;
    end
  end

  // R2
  redirect_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mode == $past(new_mode) && addr == $past(new_addr)));

  // R5
  step_by_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !take) |=> (addr == $past(addr) + STEP));
endmodule

// File: rtl/fetch_pack.sv
module fetch_pack
  import fetch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  isa_e                 mode,
  input  logic [AW-1:0]        addr,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  input  logic [HW_BITS-1:0]   mem_data,
  output logic                 xfer,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_BITS-1:0] out_data,
  output logic                 out_wide,
  output logic [AW-1:0]        out_pc
);
  localparam logic [AW-1:0] STEP = AW'(HW_STEP);

  logic               lo_have;
  logic [HW_BITS-1:0] lo_data;
  logic               room;
  logic               first_half;
  logic               done;

  assign room       = !out_valid || out_ready;
  assign first_half = (mode == ISA_WIDE) && !lo_have;
  assign mem_valid  = !flush && (first_half || room);
  assign xfer       = mem_valid && mem_ready;
  assign done       = xfer && !first_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_have   <= 1'b0;
      lo_data   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_wide  <= 1'b0;
      out_pc    <= '0;
    end else if (flush) begin
      lo_have   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (xfer && first_half) begin
        lo_have <= 1'b1;
        lo_data <= mem_data;
      end
      if (done) begin
        out_valid <= 1'b1;
        lo_have   <= 1'b0;
        if (mode == ISA_WIDE) begin
          out_data <= {mem_data, lo_data};
          out_wide <= 1'b1;
          out_pc   <= addr - STEP;
        end else begin
          out_data <= {{HW_BITS{1'b0}}, mem_data};
          out_wide <= 1'b0;
          out_pc   <= addr;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R10
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_data) && $stable(out_pc) && $stable(out_wide)));

  // R3
  wide_first_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && first_half) |-> (addr[1:0] == 2'b00));

  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wide) |-> (out_data[WORD_BITS-1:HW_BITS] == '0));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: rtl/dual_isa_fetch.sv
module dual_isa_fetch
  import fetch_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  parameter logic [AW-1:0] EXC_VECTOR = 32'h0000_0040
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 br_valid,
  input  logic [AW-1:0]        br_target,
  input  logic                 exc_req,
  input  logic                 eret_valid,
  input  logic [AW-1:0]        eret_addr,
  input  logic                 eret_mode,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [AW-1:0]        mem_req_addr,
  input  logic [HW_BITS-1:0]   mem_rsp_data,
  output logic                 instr_valid,
  input  logic                 instr_ready,
  output logic [WORD_BITS-1:0] instr_data,
  output logic                 instr_wide,
  output logic [AW-1:0]        instr_pc,
  output logic [AW-1:0]        pc_view,
  output logic                 cur_mode
);
  localparam logic [AW-1:0] WIDE_AHEAD   = AW'(WIDE_PC_AHEAD);
  localparam logic [AW-1:0] NARROW_AHEAD = AW'(NARROW_PC_AHEAD);

  logic          take;
  isa_e          new_mode;
  logic [AW-1:0] new_addr;
  logic          xfer;
  isa_e          mode;
  logic [AW-1:0] addr;

  fetch_redirect #(.AW(AW), .EXC_VECTOR(EXC_VECTOR)) redir_u (
    .clk(clk), .rst_n(rst_n),
    .exc_req(exc_req), .ret_req(eret_valid), .ret_addr(eret_addr), .ret_mode(eret_mode),
    .br_req(br_valid), .br_target(br_target),
    .take(take), .new_mode(new_mode), .new_addr(new_addr)
  );

  fetch_seq #(.AW(AW), .RESET_ADDR(RESET_ADDR)) seq_u (
    .clk(clk), .rst_n(rst_n),
    .take(take), .new_mode(new_mode), .new_addr(new_addr), .xfer(xfer),
    .mode(mode), .addr(addr)
  );

  fetch_pack #(.AW(AW)) pack_u (
    .clk(clk), .rst_n(rst_n), .flush(take), .mode(mode), .addr(addr),
    .mem_valid(mem_req_valid), .mem_ready(mem_req_ready), .mem_data(mem_rsp_data),
    .xfer(xfer),
    .out_valid(instr_valid), .out_ready(instr_ready), .out_data(instr_data),
    .out_wide(instr_wide), .out_pc(instr_pc)
  );

  assign mem_req_addr = addr;
  assign cur_mode     = mode;
  assign pc_view      = instr_pc + (instr_wide ? WIDE_AHEAD : NARROW_AHEAD);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !take) |=> $stable(mem_req_addr));

  // R11
  addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[0] == 1'b0));

  // R6
  exc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (cur_mode == 1'b0 && mem_req_addr == EXC_VECTOR));

  // R3
  width_follows_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> (instr_wide == (cur_mode == 1'b0)));
endmodule

// File: tb/dual_isa_fetch_tb_top.sv
module dual_isa_fetch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXC_VEC = 32'h0000_0040;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] data;
    logic        wide;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid, exc_req, eret_valid, eret_mode;
  logic [31:0] br_target, eret_addr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic [15:0] mem_rsp_data;
  logic        instr_valid, instr_ready, instr_wide, cur_mode;
  logic [31:0] instr_data, instr_pc, pc_view;
  logic        mem_hold;

  exp_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] hw(logic [31:0] a);
    return a[16:1] ^ 16'h9C35;
  endfunction

  assign mem_rsp_data = hw(mem_req_addr);

  dual_isa_fetch #(.AW(32), .RESET_ADDR(32'h0), .EXC_VECTOR(EXC_VEC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_target(br_target), .exc_req(exc_req),
    .eret_valid(eret_valid), .eret_addr(eret_addr), .eret_mode(eret_mode),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_data(mem_rsp_data),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_data(instr_data),
    .instr_wide(instr_wide), .instr_pc(instr_pc), .pc_view(pc_view), .cur_mode(cur_mode)
  );

  // memory side: stalls on a fixed pattern, or fully while mem_hold is set
  always @(negedge clk) mem_req_ready = !mem_hold && (cyc % 5 != 3);

  // monitor: accepts only while items are expected, compares in order
  always @(negedge clk) begin
    exp_t e;
    instr_ready = (sb_q.size() > 0) && (cyc % 4 != 2);
    #1;
    if (instr_valid && instr_ready) begin
      e = sb_q.pop_front();
      checks++;
      if (instr_data !== e.data || instr_pc !== e.pc || instr_wide !== e.wide) begin
        fails++;
        $display("FAIL %s: pc=%h data=%h wide=%0d expected pc=%h data=%h wide=%0d",
                 e.tag, instr_pc, instr_data, instr_wide, e.pc, e.data, e.wide);
      end
      checks++;
      if (pc_view !== e.pc + (e.wide ? 32'd8 : 32'd4)) begin
        fails++;
        $display("FAIL R8: pc_view=%h expected %h", pc_view, e.pc + (e.wide ? 32'd8 : 32'd4));
      end
    end
  end

  task automatic push_run(logic [31:0] start, logic wide, int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.pc   = start + i * (wide ? 4 : 2);
      e.data = wide ? {hw(e.pc + 2), hw(e.pc)} : {16'h0, hw(e.pc)};
      e.wide = wide;
      e.tag  = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic redirect(logic br, logic [31:0] bt, logic ex, logic er,
                          logic [31:0] ea, logic em);
    @(negedge clk);
    br_valid = br; br_target = bt; exc_req = ex;
    eret_valid = er; eret_addr = ea; eret_mode = em;
    @(negedge clk);
    br_valid = 0; exc_req = 0; eret_valid = 0;
  endtask

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_all();
    logic [31:0] d0, p0;
    rst_n = 0; br_valid = 0; exc_req = 0; eret_valid = 0; eret_mode = 0;
    br_target = 0; eret_addr = 0; mem_hold = 0;
    repeat (3) @(negedge clk);
    #2;
    check_val("R1 instr_valid", {31'h0, instr_valid}, 32'h0);
    check_val("R1 cur_mode", {31'h0, cur_mode}, 32'h0);
    check_val("R1 mem_req_addr", mem_req_addr, 32'h0);
    @(negedge clk);
    rst_n = 1;
    push_run(32'h0, 1'b1, 3, "R1 R3 R5");
    drain();

    // R10: output stalled with nothing expected; it must hold
    repeat (4) @(negedge clk);
    #3; d0 = instr_data; p0 = instr_pc;
    repeat (3) @(negedge clk);
    #3;
    check_val("R10 valid held", {31'h0, instr_valid}, 32'h1);
    check_val("R10 data held", instr_data, d0);
    check_val("R10 pc held", instr_pc, p0);

    // R2 odd target into narrow mode, with the memory held off (R11)
    @(negedge clk); mem_hold = 1;
    br_valid = 1; br_target = 32'h0000_0201;
    @(negedge clk); br_valid = 0;
    #2;
    check_val("R2 mode narrow", {31'h0, cur_mode}, 32'h1);
    check_val("R11 req valid", {31'h0, mem_req_valid}, 32'h1);
    check_val("R2 aligned addr", mem_req_addr, 32'h0000_0200);
    repeat (3) @(negedge clk);
    #2;
    check_val("R11 addr held", mem_req_addr, 32'h0000_0200);
    mem_hold = 0;
    push_run(32'h200, 1'b0, 5, "R2 R4 R5");
    drain();

    // R2 even target back to wide mode, bits 1:0 cleared
    redirect(1, 32'h0000_0302, 0, 0, 0, 0);
    #2; check_val("R2 mode wide", {31'h0, cur_mode}, 32'h0);
    push_run(32'h300, 1'b1, 4, "R2 R3 R9");
    drain();

    // narrow stream, then exception colliding with return and branch
    redirect(1, 32'h0000_0401, 0, 0, 0, 0);
    push_run(32'h400, 1'b0, 2, "R2 R4");
    drain();
    redirect(1, 32'h0000_0701, 1, 1, 32'h0000_0501, 1);
    #2; check_val("R6 mode wide", {31'h0, cur_mode}, 32'h0);
    push_run(EXC_VEC, 1'b1, 3, "R6 R9");
    drain();

    // R7 return: saved mode 0 wins over odd address and a same-cycle branch
    redirect(1, 32'h0000_0701, 0, 1, 32'h0000_0501, 0);
    #2; check_val("R7 mode wide", {31'h0, cur_mode}, 32'h0);
    push_run(32'h500, 1'b1, 3, "R7 R3");
    drain();

    // R7 return into narrow mode
    redirect(0, 32'h0, 0, 1, 32'h0000_0603, 1);
    #2; check_val("R7 mode narrow", {31'h0, cur_mode}, 32'h1);
    push_run(32'h602, 1'b0, 4, "R7 R4 R5");
    drain();

    // R9: wide stall leaves a half-joined word, then switch to narrow
    redirect(1, 32'h0000_0800, 0, 0, 0, 0);
    push_run(32'h800, 1'b1, 2, "R9 R3");
    drain();
    repeat (6) @(negedge clk);
    redirect(1, 32'h0000_0903, 0, 0, 0, 0);
    push_run(32'h902, 1'b0, 3, "R9 R4");
    drain();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R9 watchdog: %0d items still expected, expected 0", sb_q.size());
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule